// File: doc/BRIEF.md
# Warp Matrix Fragment Loader

This block fills the operand registers of a 32-lane SIMD group with one, two or four 8x8 tiles of 16-bit values held in a local scratchpad. Every lane hands in one byte address, and each address names one tile row on its own, so a tile's rows may be scattered anywhere in the scratchpad. The block fetches one 128-bit scratchpad line per cycle. It then spreads each line over the lanes in the fixed interleaved pattern that a matrix-multiply datapath expects. A transpose option supports tiles that are stored column by column.

Requests go in through a plain start pulse and leave through a done pulse. Control pins carry no valid/ready pair. The block accepts a request only while `busy_o` is low, and it drops a start pulse that arrives while `busy_o` is high. The lane registers hold their contents until the next successful operation overwrites them, so the output side never applies back-pressure. The scratchpad has a one-line write port, which is used to preload data before an operation starts.

Top module: `frag_loader`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are low and every bit of `lane_regs_o` is zero.
- R2: `cnt_mode_i` sets the tile count T: 2'b00 loads 1 tile, 2'b01 loads 2 tiles, and 2'b10 or 2'b11 load 4 tiles. Registers of tiles numbered T or above keep their previous values.
- R3: Lane L supplies the address of row L%8 of tile L/8, and the scratchpad line index is the address shifted right by 4. Addresses from lanes with L/8 >= T are ignored, even when they are misaligned.
- R4: Without transpose, the register of tile t in lane L receives the elements at row L/4 of tile t. The low half (bits 15:0) holds column 2*(L%4) and the high half holds column 2*(L%4)+1. Column c of a scratchpad line sits at bits 16c+15:16c. Register t of lane L is `lane_regs_o[(L*4+t)*32 +: 32]`.
- R5: With transpose, the low half of register t in lane L holds the element at row 2*(L%4), column L/4 of tile t. The high half holds the element at row 2*(L%4)+1 of the same column.
- R6: `busy_o` rises on the edge that accepts start. `done_o` is high for exactly one cycle, T*8+1 rising edges after that edge, and it is high in the same cycle that the final register values and a low `busy_o` appear.
- R7: If any active lane's address has nonzero bits 3:0, the block raises `err_o` on the accepting edge. In that case `busy_o` stays low, no done pulse follows and no lane register changes. `err_o` stays high until the next accepted start clears it.
- R8: A start pulse that arrives while `busy_o` is high has no effect. The running operation finishes with its own data, produces a single done pulse and sets no error.
- R9: A scratchpad write with `spad_wr_en_i` high stores `spad_wr_line_i` at `spad_wr_idx_i` within one cycle, and later operations read the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse |
| cnt_mode_i | input | 2 | Tile count select |
| transpose_i | input | 1 | Column-major distribution |
| row_addr_i | input | 32*ADDR_W | Per-lane row byte address, lane L at bits L*ADDR_W |
| spad_wr_en_i | input | 1 | Scratchpad write strobe |
| spad_wr_idx_i | input | ADDR_W-4 | Scratchpad line index to write |
| spad_wr_line_i | input | 128 | Scratchpad line data |
| lane_regs_o | output | 4096 | Four 32-bit registers per lane |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Misaligned-address abort flag |

## Verification
The bench builds the block with its default ADDR_W of 10, which gives a 64-line scratchpad. With that size, line indexes are drawn by modular scrambling across the whole memory, and every line can be refilled between runs with a new salt. The fixed lane and tile geometry lets all 32 lanes and all four register slots be compared word by word against a model image kept in the bench. The same comparison covers stale registers left over after a smaller tile count.

// File: rtl/frag_pkg.sv
package frag_pkg;
  localparam int ELEM_W        = 16;
  localparam int TILE_DIM      = 8;
  localparam int MAX_TILES     = 4;
  localparam int LANES         = 32;
  localparam int LINE_W        = ELEM_W * TILE_DIM;
  localparam int REG_W         = 2 * ELEM_W;
  localparam int LANES_PER_ROW = TILE_DIM / 2;
  localparam int SEQ_W         = $clog2(MAX_TILES * TILE_DIM);
  localparam int TILE_W        = $clog2(MAX_TILES);
  localparam int ROW_W         = $clog2(TILE_DIM);
  localparam int OUT_W         = LANES * MAX_TILES * REG_W;
  localparam int ALIGN_W       = $clog2(LINE_W / 8);

  typedef enum logic [1:0] {
    CNT_ONE  = 2'b00,
    CNT_TWO  = 2'b01,
    CNT_FOUR = 2'b10,
    CNT_ALT4 = 2'b11
  } tile_cnt_e;

  function automatic logic [2:0] tiles_for(input logic [1:0] mode);
    case (tile_cnt_e'(mode))
      CNT_ONE: return 3'd1;
      CNT_TWO: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [SEQ_W:0] rows_for(input logic [1:0] mode);
    return (SEQ_W + 1)'(tiles_for(mode)) << ROW_W;
  endfunction
endpackage

// File: rtl/frag_spad.sv
module frag_spad
  import frag_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [LINE_W-1:0] rd_line_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [LINE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_line_i;
    if (rd_en_i) rd_line_o <= mem_q[rd_idx_i];
  end
endmodule

// File: rtl/frag_addr_unpack.sv
module frag_addr_unpack
  import frag_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int IDX_W = ADDR_W - ALIGN_W
) (
  input  logic [LANES*ADDR_W-1:0] addrs_i,
  input  logic [2:0]              tiles_i,
  output logic [LANES*IDX_W-1:0]  idx_o,
  output logic                    bad_o
);
  logic [LANES-1:0] lane_bad;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [2:0] TILE_OF = 3'(l / TILE_DIM);
    assign idx_o[l*IDX_W +: IDX_W] = addrs_i[l*ADDR_W+ALIGN_W +: IDX_W];
    assign lane_bad[l] = (TILE_OF < tiles_i) && (addrs_i[l*ADDR_W +: ALIGN_W] != '0);
  end

  assign bad_o = |lane_bad;
endmodule

// File: rtl/frag_lane_file.sv
module frag_lane_file
  import frag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [TILE_W-1:0] tile_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              trans_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [OUT_W-1:0]  regs_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar t = 0; t < MAX_TILES; t++) begin : g_tile
      for (genvar h = 0; h < 2; h++) begin : g_half
        // normal: row l/4 feeds this cell; transpose: column l/4 of two rows
        localparam logic [ROW_W-1:0] NROW = ROW_W'(l / LANES_PER_ROW);
        localparam logic [ROW_W-1:0] TROW = ROW_W'(2 * (l % LANES_PER_ROW) + h);
        localparam int NCOL = 2 * (l % LANES_PER_ROW) + h;
        localparam int TCOL = l / LANES_PER_ROW;

        logic              hit;
        logic [ELEM_W-1:0] cell_q;

        assign hit = wr_en_i && (tile_i == TILE_W'(t)) &&
                     (trans_i ? (row_i == TROW) : (row_i == NROW));

        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)  cell_q <= '0;
          else if (hit) cell_q <= trans_i ? line_i[TCOL*ELEM_W +: ELEM_W]
                                          : line_i[NCOL*ELEM_W +: ELEM_W];
        end

        assign regs_o[(l*MAX_TILES + t)*REG_W + h*ELEM_W +: ELEM_W] = cell_q;
      end
    end
  end
endmodule

// File: rtl/frag_loader.sv
module frag_loader
  import frag_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int IDX_W = ADDR_W - ALIGN_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [1:0]              cnt_mode_i,
  input  logic                    transpose_i,
  input  logic [LANES*ADDR_W-1:0] row_addr_i,
  input  logic                    spad_wr_en_i,
  input  logic [IDX_W-1:0]        spad_wr_idx_i,
  input  logic [LINE_W-1:0]       spad_wr_line_i,
  output logic [OUT_W-1:0]        lane_regs_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o
);
  logic                   busy_q, done_q, err_q, trans_q, rd_vld_q;
  logic [SEQ_W:0]         rows_q, iss_q;
  logic [SEQ_W-1:0]       rd_seq_q;
  logic [IDX_W-1:0]       idx_q [LANES];
  logic [LANES*IDX_W-1:0] idx_in;
  logic                   misalign, accept, issue, last;
  logic [LINE_W-1:0]      rd_line;

  frag_addr_unpack #(.ADDR_W(ADDR_W)) u_addr (
    .addrs_i (row_addr_i),
    .tiles_i (tiles_for(cnt_mode_i)),
    .idx_o   (idx_in),
    .bad_o   (misalign)
  );

  assign accept = start_i && !busy_q;
  assign issue  = busy_q && (iss_q < rows_q);
  assign last   = rd_vld_q && ({1'b0, rd_seq_q} == rows_q - 1'b1);

  frag_spad #(.IDX_W(IDX_W)) u_spad (
    .clk_i     (clk_i),
    .wr_en_i   (spad_wr_en_i),
    .wr_idx_i  (spad_wr_idx_i),
    .wr_line_i (spad_wr_line_i),
    .rd_en_i   (issue),
    .rd_idx_i  (idx_q[iss_q[SEQ_W-1:0]]),
    .rd_line_o (rd_line)
  );

  always_ff @(posedge clk_i) begin
    if (accept && !misalign) begin
      for (int i = 0; i < LANES; i++) idx_q[i] <= idx_in[i*IDX_W +: IDX_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      trans_q  <= 1'b0;
      rd_vld_q <= 1'b0;
      rows_q   <= '0;
      iss_q    <= '0;
      rd_seq_q <= '0;
    end else begin
      done_q   <= 1'b0;
      rd_vld_q <= issue;
      if (issue) begin
        rd_seq_q <= iss_q[SEQ_W-1:0];
        iss_q    <= iss_q + 1'b1;
      end
      if (accept) begin
        if (misalign) begin
          err_q <= 1'b1;
        end else begin
          err_q   <= 1'b0;
          busy_q  <= 1'b1;
          iss_q   <= '0;
          rows_q  <= rows_for(cnt_mode_i);
          trans_q <= transpose_i;
        end
      end
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  frag_lane_file u_lanes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (rd_vld_q),
    .tile_i  (rd_seq_q[SEQ_W-1 -: TILE_W]),
    .row_i   (rd_seq_q[ROW_W-1:0]),
    .trans_i (trans_q),
    .line_i  (rd_line),
    .regs_o  (lane_regs_o)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/frag_loader_chk.sv
module frag_loader_chk
  import frag_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [OUT_W-1:0] lane_regs_o
);
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_busy_ends_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  assert_busy_needs_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_err_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);

  assert_regs_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(lane_regs_o));
endmodule

bind frag_loader frag_loader_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .lane_regs_o (lane_regs_o)
);

// File: tb/frag_loader_tb_top.sv
module frag_loader_tb_top;
  import frag_pkg::*;

  localparam int AW    = 10;
  localparam int IW    = AW - ALIGN_W;
  localparam int DEPTH = 1 << IW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic              trans = 1'b0;
  logic [LANES*AW-1:0] addr_flat = '0;
  logic              wr_en = 1'b0;
  logic [IW-1:0]     wr_idx = '0;
  logic [LINE_W-1:0] wr_line = '0;
  logic [OUT_W-1:0]  regs;
  logic              busy, done, err;

  always #10 clk = ~clk;

  frag_loader #(.ADDR_W(AW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .cnt_mode_i (mode),
    .transpose_i (trans), .row_addr_i (addr_flat), .spad_wr_en_i (wr_en),
    .spad_wr_idx_i (wr_idx), .spad_wr_line_i (wr_line),
    .lane_regs_o (regs), .busy_o (busy), .done_o (done), .err_o (err)
  );

  typedef struct {
    logic [OUT_W-1:0] img;
    int               lat;
    string            tag;
  } item_t;

  item_t             sb[$];
  item_t             cur;
  logic [LINE_W-1:0] model [DEPTH];
  logic [OUT_W-1:0]  exp_img = '0;
  logic [AW-1:0]     a [LANES];
  int total = 0, bad = 0, cyc = 0, start_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // scoreboard monitor: compares the register image at every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8", "unexpected done pulse", 32'd1, 32'd0);
      end else begin
        int miss;
        cur  = sb.pop_front();
        miss = -1;
        for (int w = 0; w < LANES*MAX_TILES; w++)
          if (miss < 0 && regs[w*REG_W +: REG_W] !== cur.img[w*REG_W +: REG_W]) miss = w;
        if (miss < 0) check(1'b1, cur.tag, "image", 32'd0, 32'd0);
        else check(1'b0, cur.tag, $sformatf("lane %0d reg %0d", miss/4, miss%4),
                   regs[miss*REG_W +: REG_W], cur.img[miss*REG_W +: REG_W]);
        check(cyc - start_cyc == cur.lat, "R6", "done latency",
              32'(cyc - start_cyc), 32'(cur.lat));
        check(!busy, "R6", "busy low with done", {31'd0, busy}, 32'd0);
      end
    end
  end

  task automatic spad_fill(input int salt);
    for (int i = 0; i < DEPTH; i++) begin
      logic [LINE_W-1:0] ln;
      for (int c = 0; c < TILE_DIM; c++) ln[c*ELEM_W +: ELEM_W] = 16'(i*16 + c + salt);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IW'(i); wr_line = ln;
      model[i] = ln;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive_start(input logic [1:0] m, input bit tr);
    @(negedge clk);
    mode = m; trans = tr; start = 1'b1;
    for (int i = 0; i < LANES; i++) addr_flat[i*AW +: AW] = a[i];
    start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] m, input bit tr, input string tag, input bit poke);
    int nt;
    logic [OUT_W-1:0] img;
    nt  = (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
    img = exp_img;
    for (int t = 0; t < nt; t++)
      for (int l = 0; l < LANES; l++)
        for (int h = 0; h < 2; h++) begin
          int r, c;
          if (!tr) begin r = l/4; c = 2*(l%4) + h; end
          else     begin r = 2*(l%4) + h; c = l/4; end
          img[(l*4 + t)*REG_W + h*ELEM_W +: ELEM_W] =
            model[a[t*8 + r] >> ALIGN_W][c*ELEM_W +: ELEM_W];
        end
    sb.push_back('{img, nt*8 + 2, tag});
    exp_img = img;
    drive_start(m, tr);
    check(busy === 1'b1, "R6", "busy after accept", {31'd0, busy}, 32'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      mode = 2'b00; trans = ~tr; start = 1'b1;
      addr_flat = '1;  // misaligned everywhere: would raise err if taken
      @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "R6", "watchdog expired", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(regs === '0, "R1", "regs zero in reset", regs[31:0], 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(regs === '0, "R1", "regs zero", regs[31:0], 32'd0);
    check({busy, done, err} === 3'b000, "R1", "flags low", {29'd0, busy, done, err}, 32'd0);

    spad_fill(0);

    // R2 R4: one tile, contiguous rows; R3: other lanes misaligned but ignored
    for (int i = 0; i < LANES; i++) a[i] = (i < 8) ? AW'(i << ALIGN_W) : AW'(i*16 + 3);
    run_op(2'b00, 1'b0, "R4", 1'b0);

    // R3: two tiles from scattered lines, upper lanes misaligned
    for (int i = 0; i < LANES; i++) a[i] = (i < 16) ? AW'(((i*7 + 3) % DEPTH) << ALIGN_W) : AW'(5);
    run_op(2'b01, 1'b0, "R3", 1'b0);

    // R4: four tiles
    for (int i = 0; i < LANES; i++) a[i] = AW'(((i*13 + 5) % DEPTH) << ALIGN_W);
    run_op(2'b10, 1'b0, "R4", 1'b0);

    // R5: four tiles transposed
    for (int i = 0; i < LANES; i++) a[i] = AW'(((i*11 + 9) % DEPTH) << ALIGN_W);
    run_op(2'b10, 1'b1, "R5", 1'b0);

    // R2: one tile transposed, tiles 1..3 keep old data
    for (int i = 0; i < LANES; i++) a[i] = AW'(((i*5 + 40) % DEPTH) << ALIGN_W);
    run_op(2'b00, 1'b1, "R2", 1'b0);

    // R2: mode 2'b11 behaves as four tiles
    for (int i = 0; i < LANES; i++) a[i] = AW'(((i*29 + 1) % DEPTH) << ALIGN_W);
    run_op(2'b11, 1'b1, "R2", 1'b0);

    // R7: misaligned active lane aborts
    for (int i = 0; i < LANES; i++) a[i] = AW'(((i*3) % DEPTH) << ALIGN_W);
    a[12] = a[12] | AW'(2);
    drive_start(2'b01, 1'b0);
    check(err === 1'b1, "R7", "err set", {31'd0, err}, 32'd1);
    check(busy === 1'b0, "R7", "busy stays low", {31'd0, busy}, 32'd0);
    repeat (40) @(negedge clk);
    check(regs === exp_img, "R7", "regs unchanged after abort", regs[31:0], exp_img[31:0]);
    check(err === 1'b1, "R7", "err held", {31'd0, err}, 32'd1);

    // R7: next accepted start clears err
    a[12] = AW'(7 << ALIGN_W);
    run_op(2'b00, 1'b0, "R7", 1'b0);
    check(err === 1'b0, "R7", "err cleared", {31'd0, err}, 32'd0);

    // R8: start while busy ignored
    for (int i = 0; i < LANES; i++) a[i] = AW'(((i*17 + 2) % DEPTH) << ALIGN_W);
    run_op(2'b10, 1'b0, "R8", 1'b1);
    repeat (40) @(negedge clk);
    check(err === 1'b0, "R8", "no err from ignored start", {31'd0, err}, 32'd0);
    check(regs === exp_img, "R8", "regs after ignored start", regs[31:0], exp_img[31:0]);

    // R9: rewrite scratchpad, reload
    spad_fill(16'h4000);
    run_op(2'b10, 1'b0, "R9", 1'b0);

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R6", "scoreboard drained", 32'(sb.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule